// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between an instruction fetch stage and a shared translation-and-memory port. Each fetch request carries a virtual address and a flag that allows 16-bit compressed instructions. The block answers with a 32-bit instruction word or a trap code. Word-aligned fetches are looked up in a direct-mapped store of fetched words. A hit is answered in the same cycle. A miss first translates the address, then reads a full word, fills the entry and answers.

A fetch to a halfword-aligned address (allowed only when compressed fetch is enabled) never uses the store. The block translates and reads that halfword. If the halfword is a compressed encoding, it is returned zero-extended. Otherwise the next halfword's address is translated on its own and read, and the two halves are joined. A misaligned address produces a trap at once, with no memory traffic. A translation fault produces an access-fault trap.

The request side is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While a response is waiting, `rsp_valid` stays high and the response holds steady until `rsp_ready` is seen. A same-cycle answer (hit or misaligned trap) is only accepted together with `rsp_ready`, so `req_ready` depends on `rsp_ready` in that case. The memory port is valid/ready on the request side and allows one outstanding request. Its response arrives as a one-cycle `mem_rsp_valid` pulse with no back-pressure.

Top module: `ifetch_cache`

## Requirements
- R1: After reset every entry is empty: `busy`, `rsp_valid` and `mem_req_valid` are low, and the first word-aligned fetch to any address misses.
- R2: A word-aligned fetch (address bits [1:0] = 0) whose entry holds a tag equal to the address with bit 0 set returns the stored word in the request cycle, with `rsp_trap` = 0, `busy` low and no memory request.
- R3: The entry index is address bits [9:2] (address/4 modulo 256). Two addresses with the same index evict each other, so refetching the first one misses.
- R4: On a word-aligned miss the block issues one translation (`mem_req_kind` = 0) of the fetch address. It then issues one 32-bit read (`mem_req_kind` = 1, `mem_req_word` = 1) of the returned physical address, fills the entry with the word, and returns it. `busy` stays high from acceptance until the response is taken.
- R5: With `req_cmp_en` = 1 and address bits [1:0] = 2, the block translates the address and issues a 16-bit read (`mem_req_word` = 0, data in bits [15:0]). A halfword whose low two bits are not both 1 is compressed and is returned zero-extended after exactly two memory requests. Such fetches never fill an entry.
- R6: If that halfword has low bits 2'b11, the block separately translates address+2 and reads that halfword. The response is {upper halfword, lower halfword} after four memory requests.
- R7: An address that is not a multiple of 4, other than the halfword case of R5, gives `rsp_trap` = 1 and `rsp_insn` = 0 in the request cycle, with no memory request.
- R8: A translation response with `mem_rsp_fault` = 1 ends the fetch with `rsp_trap` = 2 and `rsp_insn` = 0, and fills no entry. This holds for the first halfword and for the second.
- R9: A pending response holds `rsp_valid` and its value until `rsp_ready`. A memory request held off by `mem_req_ready` keeps its valid and address unchanged.
- R10: A translation response returns the physical address in `mem_rsp_data`. Read requests carry the translated address, and translation requests carry the virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request accepted this cycle |
| req_addr | input | ADDR_W | Virtual fetch address |
| req_cmp_en | input | 1 | Compressed instructions allowed |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_insn | output | 32 | Instruction word (0 on a trap) |
| rsp_trap | output | 2 | 0 none, 1 misaligned fetch, 2 access fault |
| busy | output | 1 | A miss or halfword fetch is in progress |
| mem_req_valid | output | 1 | Memory port request valid |
| mem_req_ready | input | 1 | Memory port accepts the request |
| mem_req_kind | output | 1 | 0 translate, 1 read |
| mem_req_word | output | 1 | For reads: 1 reads 32 bits, 0 reads 16 bits |
| mem_req_addr | output | ADDR_W | Virtual (translate) or physical (read) address |
| mem_rsp_valid | input | 1 | One-cycle response pulse |
| mem_rsp_data | input | ADDR_W | Physical address or read data |
| mem_rsp_fault | input | 1 | Translation fault |

## Verification
The bench aims at aliasing addresses that share an index. A design that compared only part of the tag, or skipped eviction, would return a stale word with no memory traffic. It refetches halfword addresses to catch a design that wrongly allocates on that path, which would make the second fetch hit. It checks the request count and order on the non-compressed halfword path, where a design that reused the first translation would read the wrong physical halfword. It places a fault on the second halfword at a page edge, where a design that filled or returned partial data would show a nonzero word or a later hit. It also stalls the response and the memory port to show that values are held.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    TRAP_NONE     = 2'd0,
    TRAP_MISALIGN = 2'd1,
    TRAP_ACCESS   = 2'd2
  } trap_e;

  typedef enum logic {
    OP_XLATE = 1'b0,
    OP_READ  = 1'b1
  } memop_e;

  typedef enum logic [1:0] {
    PH_WORD = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XLATE = 2'd1,
    ST_READ  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;

  function automatic logic is_compressed(input logic [15:0] half);
    return half[1:0] != 2'b11;
  endfunction

endpackage

// File: rtl/ifc_classify.sv
module ifc_classify (
  input  logic [1:0] low_bits,
  input  logic       cmp_en,
  output logic       is_word,
  output logic       is_half,
  output logic       is_bad
);
  always_comb begin
    is_word = (low_bits == 2'b00);
    is_half = cmp_en && (low_bits == 2'b10);
    is_bad  = !is_word && !is_half;
  end
endmodule

// File: rtl/ifc_store.sv
module ifc_store #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [31:0]       lk_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [31:0]       fill_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ADDR_W-1:0] tag_q  [ENTRIES];
  logic [31:0]       word_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] fill_idx;

  assign lk_idx   = lk_addr[IDX_W+1:2];
  assign fill_idx = fill_addr[IDX_W+1:2];

  always_comb begin
    lk_hit  = (lk_addr[1:0] == 2'b00) &&
              (tag_q[lk_idx] == {lk_addr[ADDR_W-1:1], 1'b1});
    lk_data = word_q[lk_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else if (fill_en) begin
      tag_q[fill_idx] <= {fill_addr[ADDR_W-1:1], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) word_q[fill_idx] <= fill_data;
  end

  // fills only ever come from the word-aligned path
  assert_fill_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> fill_addr[1:0] == 2'b00);

endmodule

// File: rtl/ifc_walker.sv
module ifc_walker #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              idle,
  input  logic              start,
  input  logic              start_half,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_kind,
  output logic              mem_req_word,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_fault,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [31:0]       fill_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_insn,
  output logic [1:0]        rsp_trap
);
  import ifc_pkg::*;

  state_e            state_q;
  phase_e            phase_q;
  logic              sent_q;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] pa_q;
  logic [15:0]       lo_q;
  logic [31:0]       res_q;
  trap_e             trap_q;
  logic              got_rsp;

  assign got_rsp = sent_q && mem_rsp_valid;

  always_comb begin
    idle          = (state_q == ST_IDLE);
    mem_req_valid = ((state_q == ST_XLATE) || (state_q == ST_READ)) && !sent_q;
    mem_req_kind  = (state_q == ST_READ) ? OP_READ : OP_XLATE;
    mem_req_word  = (state_q == ST_READ) && (phase_q == PH_WORD);
    if (state_q == ST_READ)     mem_req_addr = pa_q;
    else if (phase_q == PH_HI)  mem_req_addr = va_q + ADDR_W'(2);
    else                        mem_req_addr = va_q;
    fill_en   = (state_q == ST_READ) && got_rsp && (phase_q == PH_WORD);
    fill_addr = va_q;
    fill_data = mem_rsp_data[31:0];
    rsp_valid = (state_q == ST_RESP);
    rsp_insn  = res_q;
    rsp_trap  = trap_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_WORD;
      sent_q  <= 1'b0;
      va_q    <= '0;
      pa_q    <= '0;
      lo_q    <= '0;
      res_q   <= '0;
      trap_q  <= TRAP_NONE;
    end else begin
      if (mem_req_valid && mem_req_ready) sent_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            va_q    <= start_addr;
            phase_q <= start_half ? PH_LO : PH_WORD;
            sent_q  <= 1'b0;
            state_q <= ST_XLATE;
          end
        end
        ST_XLATE: begin
          if (got_rsp) begin
            sent_q <= 1'b0;
            if (mem_rsp_fault) begin
              res_q   <= '0;
              trap_q  <= TRAP_ACCESS;
              state_q <= ST_RESP;
            end else begin
              pa_q    <= mem_rsp_data;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (got_rsp) begin
            sent_q <= 1'b0;
            unique case (phase_q)
              PH_WORD: begin
                res_q   <= mem_rsp_data[31:0];
                trap_q  <= TRAP_NONE;
                state_q <= ST_RESP;
              end
              PH_LO: begin
                if (is_compressed(mem_rsp_data[15:0])) begin
                  res_q   <= {16'h0000, mem_rsp_data[15:0]};
                  trap_q  <= TRAP_NONE;
                  state_q <= ST_RESP;
                end else begin
                  lo_q    <= mem_rsp_data[15:0];
                  phase_q <= PH_HI;
                  state_q <= ST_XLATE;
                end
              end
              default: begin
                res_q   <= {mem_rsp_data[15:0], lo_q};
                trap_q  <= TRAP_NONE;
                state_q <= ST_RESP;
              end
            endcase
          end
        end
        default: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_insn) && $stable(rsp_trap));

  assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // a faulted fetch never leaves partial data behind
  assert_fault_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap == TRAP_ACCESS |-> rsp_insn == 32'h0);

endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cmp_en,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_insn,
  output logic [1:0]        rsp_trap,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_kind,
  output logic              mem_req_word,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_fault
);
  import ifc_pkg::*;

  logic              is_word, is_half, is_bad;
  logic              lk_hit;
  logic [31:0]       lk_data;
  logic              fill_en;
  logic [ADDR_W-1:0] fill_addr;
  logic [31:0]       fill_data;
  logic              idle;
  logic              wk_rsp_valid;
  logic [31:0]       wk_insn;
  logic [1:0]        wk_trap;
  logic              quick_kind;
  logic              quick;
  logic              start;

  ifc_classify u_cls (
    .low_bits (req_addr[1:0]),
    .cmp_en   (req_cmp_en),
    .is_word  (is_word),
    .is_half  (is_half),
    .is_bad   (is_bad)
  );

  ifc_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (req_addr),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .fill_en   (fill_en),
    .fill_addr (fill_addr),
    .fill_data (fill_data)
  );

  ifc_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle          (idle),
    .start         (start),
    .start_half    (is_half),
    .start_addr    (req_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_kind  (mem_req_kind),
    .mem_req_word  (mem_req_word),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_fault (mem_rsp_fault),
    .fill_en       (fill_en),
    .fill_addr     (fill_addr),
    .fill_data     (fill_data),
    .rsp_valid     (wk_rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_insn      (wk_insn),
    .rsp_trap      (wk_trap)
  );

  always_comb begin
    quick_kind = (is_word && lk_hit) || is_bad;
    quick      = idle && req_valid && quick_kind;
    start      = idle && req_valid && !quick_kind;
    req_ready  = idle && (quick_kind ? rsp_ready : 1'b1);
    rsp_valid  = quick || wk_rsp_valid;
    busy       = !idle;
    if (quick) begin
      rsp_insn = is_bad ? 32'h0 : lk_data;
      rsp_trap = is_bad ? TRAP_MISALIGN : TRAP_NONE;
    end else begin
      rsp_insn = wk_insn;
      rsp_trap = wk_trap;
    end
  end

  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_valid && is_word && lk_hit |-> !mem_req_valid && !busy);

  assert_trap_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap == TRAP_MISALIGN |-> !busy && req_addr[1:0] != 2'b00);

  assert_busy_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy && !rsp_valid);

endmodule

// File: tb/ifetch_cache_tb.sv
module ifetch_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_cmp_en = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_insn;
  logic [1:0]  rsp_trap;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_kind;
  logic        mem_req_word;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_fault = 1'b0;

  int checks = 0;
  int fails  = 0;
  int nreq   = 0;
  int cyc    = 0;
  int lat    = 0;
  logic        p_kind, p_word;
  logic [31:0] p_addr;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [31:0] mtag [256];

  always #5 clk = ~clk;

  ifetch_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cmp_en(req_cmp_en), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_insn(rsp_insn), .rsp_trap(rsp_trap), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_kind(mem_req_kind), .mem_req_word(mem_req_word),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault)
  );

  function automatic logic [31:0] xl(input logic [31:0] va);
    return va ^ 32'h0010_0000;
  endfunction
  function automatic logic faulty(input logic [31:0] va);
    return va[31:12] == 20'h00077;
  endfunction
  function automatic logic [15:0] half_at(input logic [31:0] pa);
    return {pa[15:2] ^ 14'h1234, pa[4:3]};
  endfunction
  function automatic logic [31:0] word_at(input logic [31:0] pa);
    return {half_at(pa | 32'd2), half_at(pa & ~32'd3)};
  endfunction

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory and translation model, plus port-rule monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    if (rst_n) begin
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R9", "held mem request",
            mem_req_addr, prev_addr);
      prev_stall <= mem_req_valid && !mem_req_ready;
      prev_addr  <= mem_req_addr;
    end
    mem_rsp_valid <= 1'b0;
    if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        mem_rsp_valid <= 1'b1;
        if (!p_kind) begin
          mem_rsp_fault <= faulty(p_addr);
          mem_rsp_data  <= xl(p_addr);
        end else begin
          mem_rsp_fault <= 1'b0;
          mem_rsp_data  <= p_word ? word_at(p_addr) : {16'hDEAD, half_at(p_addr)};
        end
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      nreq++;
      lat    <= 2;
      p_kind <= mem_req_kind;
      p_word <= mem_req_word;
      p_addr <= mem_req_addr;
      // R10: reads carry translated (bit 20 set) addresses, translations virtual ones
      chk(mem_req_addr[20] == mem_req_kind, "R10", "request address space",
          {31'd0, mem_req_addr[20]}, {31'd0, mem_req_kind});
    end
  end

  task automatic fetch(input logic [31:0] a, input logic c, input int hold, input string rq);
    logic [31:0] e_insn;
    logic [1:0]  e_trap;
    logic        e_fast;
    logic        e_fill;
    int          e_n;
    int          n0;
    logic [15:0] lo;
    e_insn = 0; e_trap = 0; e_fast = 0; e_fill = 0; e_n = 0;
    if (a[1:0] != 2'b00 && !(c && a[1:0] == 2'b10)) begin
      e_trap = 2'd1; e_fast = 1'b1;
    end else if (a[1:0] == 2'b00) begin
      if (mtag[a[9:2]] == (a | 32'd1)) begin
        e_fast = 1'b1; e_insn = word_at(xl(a));
      end else if (faulty(a)) begin
        e_trap = 2'd2; e_n = 1;
      end else begin
        e_insn = word_at(xl(a)); e_n = 2; e_fill = 1'b1;
      end
    end else begin
      if (faulty(a)) begin
        e_trap = 2'd2; e_n = 1;
      end else begin
        lo = half_at(xl(a));
        if (lo[1:0] != 2'b11) begin
          e_insn = {16'h0, lo}; e_n = 2;
        end else if (faulty(a + 2)) begin
          e_trap = 2'd2; e_n = 3;
        end else begin
          e_insn = {half_at(xl(a + 2)), lo}; e_n = 4;
        end
      end
    end
    n0 = nreq;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmp_en = c; rsp_ready = 1'b1;
    #1;
    if (e_fast) begin
      chk(rsp_valid && req_ready && !busy, rq, "same-cycle answer", {29'd0, rsp_valid, req_ready, busy}, 32'h6);
      chk(rsp_insn == e_insn, rq, "insn", rsp_insn, e_insn);
      chk(rsp_trap == e_trap, rq, "trap", {30'd0, rsp_trap}, {30'd0, e_trap});
      @(negedge clk);
      req_valid = 1'b0;
    end else begin
      chk(req_ready && !rsp_valid, rq, "miss accepted", {30'd0, req_ready, rsp_valid}, 32'h2);
      @(negedge clk);
      req_valid = 1'b0;
      rsp_ready = (hold == 0);
      for (int w = 0; w < 200; w++) begin
        #1;
        if (rsp_valid) break;
        chk(busy, rq, "busy during miss", {31'd0, busy}, 32'd1);
        @(negedge clk);
      end
      chk(rsp_valid && rsp_insn == e_insn, rq, "insn", rsp_insn, e_insn);
      chk(rsp_trap == e_trap, rq, "trap", {30'd0, rsp_trap}, {30'd0, e_trap});
      for (int h = 0; h < hold; h++) begin
        @(negedge clk); #1;
        chk(rsp_valid && rsp_insn == e_insn, "R9", "held response", rsp_insn, e_insn);
      end
      rsp_ready = 1'b1;
      @(negedge clk); #1;
      chk(!busy && !rsp_valid, rq, "idle after response", {30'd0, busy, rsp_valid}, 32'd0);
    end
    chk(nreq - n0 == e_n, rq, "memory request count", nreq - n0, e_n);
    if (e_fill) mtag[a[9:2]] = a | 32'd1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mtag[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !rsp_valid && !mem_req_valid, "R1", "reset outputs",
        {29'd0, busy, rsp_valid, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    fetch(32'h0000_1000, 1'b0, 0, "R1");   // cold miss
    fetch(32'h0000_1000, 1'b0, 0, "R2");   // hit
    fetch(32'h0000_1400, 1'b1, 0, "R3");   // same index, evicts
    fetch(32'h0000_1000, 1'b0, 0, "R3");   // misses again
    fetch(32'h0000_1004, 1'b0, 0, "R4");   // other index miss
    fetch(32'h0000_1000, 1'b1, 0, "R2");   // hit, both fills kept
    fetch(32'h0000_1004, 1'b0, 0, "R2");
    fetch(32'h0000_2002, 1'b1, 0, "R5");   // compressed halfword
    fetch(32'h0000_2002, 1'b1, 0, "R5");   // not allocated
    fetch(32'h0000_2000, 1'b1, 0, "R5");   // word at same index still misses
    fetch(32'h0000_201A, 1'b1, 0, "R6");   // non-compressed, two halves
    fetch(32'h0000_201A, 1'b1, 0, "R6");
    fetch(32'h0000_3001, 1'b1, 0, "R7");
    fetch(32'h0000_3002, 1'b0, 0, "R7");
    fetch(32'h0000_3003, 1'b0, 0, "R7");
    fetch(32'h0007_7000, 1'b0, 0, "R8");   // translation fault
    fetch(32'h0007_7000, 1'b0, 0, "R8");   // not filled
    fetch(32'h0007_6FFE, 1'b1, 0, "R8");   // fault on second half
    fetch(32'h0000_5000, 1'b0, 3, "R9");   // stalled response
    fetch(32'h0000_5000, 1'b0, 0, "R2");
    fetch(32'h0000_5400, 1'b0, 2, "R10");
    fetch(32'h0000_5000, 1'b0, 0, "R3");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule